// File: doc/BRIEF.md
# Angle PWM Frame Encoder

This block turns a 12-bit absolute angle into a pulse-width encoded line that repeats a frame of fixed length. The frame is timed by a PWM clock, which is a tick made by dividing the system clock by a parameter. Each frame opens with a run of high clocks that marks its start. A short flag field follows, which is high while the source is healthy. Next comes a long data field whose leading high run grows by one clock per angle LSB. The frame closes with a low gap.

A receiver finds the angle by measuring the high time of each frame and subtracting the fixed head. When the fault input is set at the start of a frame, that frame is sent as a head-only pulse: the flag field and the whole data field stay low. The angle and the fault flag are taken once per frame, on the tick that starts it, so a frame never mixes two samples.

The line is held low while the enable input is low. The first frame starts one divided clock after enable rises.

Top module: `pwmf_encoder`

## Requirements
- R1: While reset is high, and in the first cycle after reset is sampled high, `pwm_o` is 0.
- R2: While enabled, a frame lasts 4119 PWM clocks, and one PWM clock is `CLK_DIV` system cycles. Rising edges of `pwm_o` are therefore exactly 4119×`CLK_DIV` system cycles apart.
- R3: With `fault_i` at 0 when a frame starts, `pwm_o` is high for one contiguous run from the frame start, of 16 + A + 1 PWM clocks for angle A. It is then low for the rest of the frame.
- R4: The data field holds 4095 clocks, so the high run saturates. Angles 4094 and 4095 both give 4111 high clocks followed by 8 low clocks.
- R5: With `fault_i` at 1 when a frame starts, `pwm_o` is high for only 12 PWM clocks in that frame, whatever the angle.
- R6: `angle_i` and `fault_i` are sampled only on the tick that starts a frame. Changes during a frame have no effect on that frame's pulse, and they apply from the next frame.
- R7: When `en_i` is sampled low, `pwm_o` is 0 in the next cycle and stays 0 while `en_i` stays low.
- R8: When `en_i` rises, `pwm_o` goes high `CLK_DIV` system cycles later, which starts a new frame at its first clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Output enable; low forces the line low and restarts the frame |
| angle_i | input | ANG_W (12) | Absolute angle, unsigned |
| fault_i | input | 1 | Fault flag; selects a head-only frame |
| pwm_o | output | 1 | Registered PWM line |

## Verification
A wrong frame position shows up within one frame as a rising-edge spacing other than 4119 divided clocks, or as a high run outside the 12 to 4111 clock window. A stale or mis-timed capture of the angle or fault flag shows up as a pulse width that belongs to the neighbouring frame's inputs. A fault in the enable path shows in the cycle after `en_i` falls, or as a first rising edge that misses the one-divided-clock latency after enable.

// File: rtl/pwmf_pkg.sv
package pwmf_pkg;
  // Frame sections in transmit order.
  typedef enum logic [1:0] {
    SEC_HEAD = 2'd0,
    SEC_FLAG = 2'd1,
    SEC_DATA = 2'd2,
    SEC_TAIL = 2'd3
  } sec_e;
endpackage

// File: rtl/pwmf_tick.sv
module pwmf_tick #(
  parameter int DIV = 111
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwmf_seq.sv
module pwmf_seq #(
  parameter int FRAME = 4119,
  parameter int POS_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  output logic [POS_W-1:0] nxt_pos,
  output logic             wrap
);
  logic [POS_W-1:0] pos_q;

  assign nxt_pos = (pos_q == POS_W'(FRAME - 1)) ? '0 : pos_q + 1'b1;
  assign wrap    = (nxt_pos == '0);

  // Parked on the last slot so the first tick after enable opens a frame.
  always_ff @(posedge clk) begin
    if (rst || !run) pos_q <= POS_W'(FRAME - 1);
    else if (tick)   pos_q <= nxt_pos;
  end
endmodule

// File: rtl/pwmf_shape.sv
module pwmf_shape
  import pwmf_pkg::*;
#(
  parameter int POS_W    = 13,
  parameter int ANG_W    = 12,
  parameter int HEAD_LEN = 12,
  parameter int FLAG_LEN = 4,
  parameter int DATA_LEN = 4095
) (
  input  logic [POS_W-1:0] pos,
  input  logic [ANG_W-1:0] ang,
  input  logic             flt,
  output logic             level
);
  localparam int DATA_LO = HEAD_LEN + FLAG_LEN;
  localparam int TAIL_LO = DATA_LO + DATA_LEN;

  sec_e             sec;
  logic [POS_W-1:0] off;

  always_comb begin
    if (pos < POS_W'(HEAD_LEN))     sec = SEC_HEAD;
    else if (pos < POS_W'(DATA_LO)) sec = SEC_FLAG;
    else if (pos < POS_W'(TAIL_LO)) sec = SEC_DATA;
    else                            sec = SEC_TAIL;
  end

  assign off = pos - POS_W'(DATA_LO);

  always_comb begin
    unique case (sec)
      SEC_HEAD: level = 1'b1;
      SEC_FLAG: level = !flt;
      SEC_DATA: level = !flt && (off <= POS_W'(ang));
      default:  level = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwmf_encoder.sv
module pwmf_encoder #(
  parameter int CLK_DIV  = 111,
  parameter int ANG_W    = 12,
  parameter int HEAD_LEN = 12,
  parameter int FLAG_LEN = 4,
  parameter int TAIL_LEN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [ANG_W-1:0] angle_i,
  input  logic             fault_i,
  output logic             pwm_o
);
  localparam int DATA_LEN = (1 << ANG_W) - 1;
  localparam int FRAME    = HEAD_LEN + FLAG_LEN + DATA_LEN + TAIL_LEN;
  localparam int POS_W    = $clog2(FRAME);

  logic             tick, wrap, level;
  logic [POS_W-1:0] nxt_pos;
  logic [ANG_W-1:0] ang_q, ang_use;
  logic             flt_q, flt_use;
  logic             out_q;

  pwmf_tick #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst(rst), .run(en_i), .tick(tick)
  );

  pwmf_seq #(.FRAME(FRAME), .POS_W(POS_W)) u_seq (
    .clk(clk), .rst(rst), .run(en_i), .tick(tick),
    .nxt_pos(nxt_pos), .wrap(wrap)
  );

  // The opening slot uses the live inputs; the rest of the frame uses the held copy.
  assign ang_use = wrap ? angle_i : ang_q;
  assign flt_use = wrap ? fault_i : flt_q;

  pwmf_shape #(
    .POS_W(POS_W), .ANG_W(ANG_W), .HEAD_LEN(HEAD_LEN),
    .FLAG_LEN(FLAG_LEN), .DATA_LEN(DATA_LEN)
  ) u_shape (
    .pos(nxt_pos), .ang(ang_use), .flt(flt_use), .level(level)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ang_q <= '0;
      flt_q <= 1'b0;
    end else if (tick && wrap) begin
      ang_q <= angle_i;
      flt_q <= fault_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) out_q <= 1'b0;
    else if (tick)    out_q <= level;
  end

  assign pwm_o = out_q;
endmodule

// File: rtl/pwmf_chk.sv
module pwmf_chk #(
  parameter int DIV   = 111,
  parameter int FRAME = 4119,
  parameter int MINHI = 12,
  parameter int MAXHI = 4111
) (
  input logic clk,
  input logic rst,
  input logic en_i,
  input logic pwm_o
);
  logic pwm_d, armed;
  int   hi_run, since_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_d      <= 1'b0;
      armed      <= 1'b0;
      hi_run     <= 0;
      since_rise <= 0;
    end else begin
      pwm_d  <= pwm_o;
      hi_run <= pwm_o ? hi_run + 1 : 0;
      if (!en_i) begin
        armed      <= 1'b0;
        since_rise <= 0;
      end else if (pwm_o && !pwm_d) begin
        armed      <= 1'b1;
        since_rise <= 1;
      end else begin
        since_rise <= since_rise + 1;
      end
    end
  end

  a_r1_low_after_reset: assert property (@(posedge clk) rst |=> !pwm_o);

  a_r7_low_when_off: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !pwm_o);

  a_r2_frame_spacing: assert property (@(posedge clk) disable iff (rst)
    (pwm_o && !pwm_d && armed) |-> (since_rise == FRAME * DIV));

  a_r3_high_window: assert property (@(posedge clk) disable iff (rst)
    (!pwm_o && pwm_d && $past(en_i)) |->
      (hi_run >= MINHI * DIV && hi_run <= MAXHI * DIV));
endmodule

bind pwmf_encoder pwmf_chk #(
  .DIV(CLK_DIV), .FRAME(FRAME), .MINHI(HEAD_LEN),
  .MAXHI(HEAD_LEN + FLAG_LEN + DATA_LEN)
) u_pwmf_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .pwm_o(pwm_o)
);

// File: tb/test_pwmf_encoder.sv
module test_pwmf_encoder;
  localparam int DIV   = 2;
  localparam int FRAME = 4119;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [11:0] ang = '0;
  logic        flt = 1'b0;
  logic        pwm;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  pwmf_encoder #(.CLK_DIV(DIV)) i_pwmf_encoder (
    .clk(clk), .rst(rst), .en_i(en), .angle_i(ang), .fault_i(flt), .pwm_o(pwm)
  );

  // angle, fault, expected high PWM clocks
  localparam int VEC [5][3] = '{
    '{0,    0, 17},
    '{1000, 0, 1017},
    '{4094, 0, 4111},
    '{4095, 0, 4111},
    '{77,   1, 12}
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Waits for a fresh frame start, then measures one full frame.
  // If mid is set, new inputs are applied a few cycles into that frame.
  task automatic measure(input bit mid, input int na, input bit nf,
                         output int h, output int l);
    while (pwm)  @(negedge clk);
    while (!pwm) @(negedge clk);
    h = 0;
    while (pwm) begin
      h++;
      if (mid && h == 5) begin ang = 12'(na); flt = nf; end
      @(negedge clk);
    end
    l = 0;
    while (!pwm) begin
      l++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int h, l, k, lowbad;
    repeat (5) @(negedge clk);
    chk("R1 reset low", pwm, 0);
    rst = 1'b0;
    lowbad = 0;
    repeat (30) begin @(negedge clk); if (pwm) lowbad++; end
    chk("R7 disabled stays low", lowbad, 0);

    // R8: first rise one divided clock after enable
    en = 1'b1;
    k = 0;
    while (!pwm && k < 100) begin @(negedge clk); k++; end
    chk("R8 enable latency", k, DIV);

    // Vector table: R3 R4 R5 and frame length R2
    for (int i = 0; i < 5; i++) begin
      ang = 12'(VEC[i][0]);
      flt = VEC[i][1][0];
      measure(1'b0, 0, 1'b0, h, l);
      chk($sformatf("R3/R4/R5 high clocks vec %0d", i), h, VEC[i][2] * DIV);
      chk($sformatf("R2 frame length vec %0d", i), h + l, FRAME * DIV);
    end

    // R6: mid-frame change ignored, applied next frame
    ang = 12'd500; flt = 1'b0;
    measure(1'b0, 0, 1'b0, h, l);
    measure(1'b1, 3000, 1'b1, h, l);
    chk("R6 mid-frame change ignored", h, 517 * DIV);
    measure(1'b0, 0, 1'b0, h, l);
    chk("R6 change applied next frame", h, 12 * DIV);
    flt = 1'b0;

    // R7: disable mid-pulse drops the line in the next cycle
    while (pwm)  @(negedge clk);
    while (!pwm) @(negedge clk);
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R7 low one cycle after disable", pwm, 0);
    lowbad = 0;
    repeat (9000) begin @(negedge clk); if (pwm) lowbad++; end
    chk("R7 held low beyond a frame", lowbad, 0);

    // R1: reset during a pulse
    en = 1'b1;
    while (!pwm) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset drops line", pwm, 0);
    repeat (3) @(negedge clk);
    chk("R1 held low in reset", pwm, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule